// File: doc/BRIEF.md
# Flash Page Fetch Engine with CPU Wait State

This engine services an instruction-cache miss from a byte-serial NAND-style flash device. When the CPU side presents a page request, the engine translates the page number through a small bad-block remap table and sends the resulting physical page address to the device. It then lets the device's first-access latency run out, waits for the device ready flag, and reads the whole page one byte at a time. The main-data bytes stream into a line buffer. The spare bytes that follow carry a caching priority and a static prefetch hint, and the engine decodes both.

For the whole miss the CPU sees its ready line low, so a plain wait/ready handshake stalls it. A one-cycle completion pulse and the return of ready coincide, and both come only after the last spare byte has been taken in. If the device never raises its ready flag, a timeout ends the fetch with an error pulse in place of the completion pulse.

Top module: `flash_page_fetch`

## Requirements
- R1: After reset, `cpu_ready` is 1 and `done`, `err`, `fl_cmd`, `fl_rd` and `lb_we` are 0.
- R2: A request seen while `cpu_ready` is high is accepted on that clock edge. In the next cycle `fl_cmd` is high for exactly one cycle, with `fl_addr` holding the physical page, and `cpu_ready` is low from that cycle on.
- R3: The page number splits into a block number (upper PAGE_W-5 bits) and a 5-bit page-in-block offset (bits 4:0). If an enabled remap entry has a bad-block value equal to the block number, the block is replaced by that entry's good block, and the lowest matching entry index wins. The offset passes through unchanged.
- R4: No byte is read (`fl_rd`) until INIT_WAIT cycles after the command cycle. After that the engine waits for `fl_rb` = 1 before the serial read starts.
- R5: Once the serial read starts, one byte of `fl_data` is sampled every BYTE_CYC cycles, and `fl_rd` is high in each sampling cycle. A page is 528 bytes: 512 main bytes, then 16 spare bytes.
- R6: Main bytes 0..511 are written in order to line-buffer addresses 0..511. Each write (`lb_we`) appears one cycle after its sampling cycle.
- R7: Spare byte 0 (page byte 512) bits 1:0 give `pri` (00 low, 01 mid, 10 high) and its bit 7 gives `pf_valid`. Spare byte 1 is the high byte and spare byte 2 the low byte of `pf_page`.
- R8: `done` pulses for one cycle right after the cycle that samples byte 527, and `cpu_ready` rises in that same cycle. `cpu_ready` is therefore low for INIT_WAIT + 1 + D + 528*BYTE_CYC cycles, where D counts the extra cycles the device stays busy.
- R9: If `fl_rb` stays low for RB_TIMEOUT cycles after the initial wait, `err` pulses once and `cpu_ready` rises in the same cycle. No `done` follows and no line-buffer write occurs.
- R10: Requests made while `cpu_ready` is low are ignored: no further `fl_cmd` is issued and `fl_addr` does not change.
- R11: A write (`map_we`) sets remap entry `map_sel` to {`map_en`, `map_bad`, `map_good`}. The entry takes effect for the next accepted request. Clearing `map_en` removes that entry's translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU miss request |
| req_page | input | PAGE_W | Logical page number requested |
| cpu_ready | output | 1 | High when idle; low stalls the CPU |
| map_we | input | 1 | Remap table write strobe |
| map_sel | input | $clog2(REMAP_N) | Remap entry index |
| map_en | input | 1 | Entry enable written |
| map_bad | input | PAGE_W-5 | Bad block number written |
| map_good | input | PAGE_W-5 | Replacement block number written |
| fl_cmd | output | 1 | One-cycle page read command |
| fl_addr | output | PAGE_W | Physical page address |
| fl_rb | input | 1 | Device ready (1) / busy (0) |
| fl_rd | output | 1 | Byte sampling strobe; device advances |
| fl_data | input | 8 | Device serial byte |
| lb_we | output | 1 | Line-buffer write enable |
| lb_addr | output | $clog2(MAIN_BYTES) | Line-buffer byte address |
| lb_data | output | 8 | Line-buffer write data |
| done | output | 1 | Fetch complete pulse |
| err | output | 1 | Device ready timeout pulse |
| pri | output | 2 | Decoded caching priority |
| pf_valid | output | 1 | Prefetch hint valid |
| pf_page | output | 16 | Prefetch page number |

## Verification
The hardest situation to reach from the ports is a device that stays busy past the end of the initial wait. Only in that case does the ready-flag sampling add cycles to the stall, and only there can the timeout fire. The bench models the device with a busy counter that restarts on every command. Each vector sets how long the device stays busy, with values both below and above the initial wait. One directed run keeps the device busy forever to force the timeout. A second request injected in the middle of every fetch, together with remap entries that overlap on the same bad block, covers the ignore rule and the lowest-index priority of the remap.

// File: rtl/flash_page_fetch.sv
module flash_page_fetch #(
  parameter int PAGE_W      = 16,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int INIT_WAIT   = 2000,
  parameter int BYTE_CYC    = 10,
  parameter int RB_TIMEOUT  = 4096,
  parameter int REMAP_N     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [PAGE_W-1:0]             req_page,
  output logic                          cpu_ready,
  input  logic                          map_we,
  input  logic [$clog2(REMAP_N)-1:0]    map_sel,
  input  logic                          map_en,
  input  logic [PAGE_W-6:0]             map_bad,
  input  logic [PAGE_W-6:0]             map_good,
  output logic                          fl_cmd,
  output logic [PAGE_W-1:0]             fl_addr,
  input  logic                          fl_rb,
  output logic                          fl_rd,
  input  logic [7:0]                    fl_data,
  output logic                          lb_we,
  output logic [$clog2(MAIN_BYTES)-1:0] lb_addr,
  output logic [7:0]                    lb_data,
  output logic                          done,
  output logic                          err,
  output logic [1:0]                    pri,
  output logic                          pf_valid,
  output logic [15:0]                   pf_page
);
  localparam int PIB_W   = 5;
  localparam int BLK_W   = PAGE_W - PIB_W;
  localparam int TOTAL   = MAIN_BYTES + SPARE_BYTES;
  localparam int IDX_W   = $clog2(TOTAL + 1);
  localparam int LB_W    = $clog2(MAIN_BYTES);
  localparam int M1      = (INIT_WAIT > BYTE_CYC) ? INIT_WAIT : BYTE_CYC;
  localparam int CNT_MAX = (M1 > RB_TIMEOUT) ? M1 : RB_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_RB, S_XFER} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  logic [REMAP_N-1:0] m_vld;
  logic [BLK_W-1:0]   m_bad  [REMAP_N];
  logic [BLK_W-1:0]   m_good [REMAP_N];
  logic [REMAP_N-1:0] hit;
  logic [BLK_W-1:0]   req_blk, phys_blk;

  assign req_blk = req_page[PAGE_W-1:PIB_W];

  for (genvar g = 0; g < REMAP_N; g++) begin : g_hit
    assign hit[g] = m_vld[g] && (m_bad[g] == req_blk);
  end

  always_comb begin
    phys_blk = req_blk;
    for (int i = REMAP_N - 1; i >= 0; i--)
      if (hit[i]) phys_blk = m_good[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_vld <= '0;
      for (int i = 0; i < REMAP_N; i++) begin
        m_bad[i]  <= '0;
        m_good[i] <= '0;
      end
    end else if (map_we) begin
      m_vld[map_sel]  <= map_en;
      m_bad[map_sel]  <= map_bad;
      m_good[map_sel] <= map_good;
    end
  end

  assign cpu_ready = (st == S_IDLE);
  assign fl_rd     = (st == S_XFER) && (cnt == CNT_W'(BYTE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      fl_cmd   <= 1'b0;
      fl_addr  <= '0;
      lb_we    <= 1'b0;
      lb_addr  <= '0;
      lb_data  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      pri      <= '0;
      pf_valid <= 1'b0;
      pf_page  <= '0;
    end else begin
      fl_cmd <= 1'b0;
      lb_we  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_INIT;
          cnt     <= '0;
          idx     <= '0;
          fl_cmd  <= 1'b1;
          fl_addr <= {phys_blk, req_page[PIB_W-1:0]};
        end
        S_INIT: if (cnt == CNT_W'(INIT_WAIT - 1)) begin
          st  <= S_RB;
          cnt <= '0;
        end else cnt <= cnt + CNT_W'(1);
        S_RB: if (fl_rb) begin
          st  <= S_XFER;
          cnt <= '0;
        end else if (cnt == CNT_W'(RB_TIMEOUT - 1)) begin
          st  <= S_IDLE;
          err <= 1'b1;
        end else cnt <= cnt + CNT_W'(1);
        S_XFER: if (fl_rd) begin
          cnt <= '0;
          idx <= idx + IDX_W'(1);
          if (idx < IDX_W'(MAIN_BYTES)) begin
            lb_we   <= 1'b1;
            lb_addr <= idx[LB_W-1:0];
            lb_data <= fl_data;
          end
          if (idx == IDX_W'(MAIN_BYTES)) begin
            pri      <= fl_data[1:0];
            pf_valid <= fl_data[7];
          end
          if (idx == IDX_W'(MAIN_BYTES + 1)) pf_page[15:8] <= fl_data;
          if (idx == IDX_W'(MAIN_BYTES + 2)) pf_page[7:0]  <= fl_data;
          if (idx == IDX_W'(TOTAL - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end else cnt <= cnt + CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_page_fetch_chk.sv
module flash_page_fetch_chk #(
  parameter int PAGE_W      = 16,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int INIT_WAIT   = 2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              fl_cmd,
  input logic [PAGE_W-1:0] fl_addr,
  input logic              fl_rd,
  input logic              done,
  input logic              err
);
  localparam int TOTAL = MAIN_BYTES + SPARE_BYTES;
  localparam int GAP_W = $clog2(INIT_WAIT + 2);
  localparam int RD_W  = $clog2(TOTAL + 1);

  logic [GAP_W-1:0] gap;
  logic [RD_W-1:0]  rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      rd_n <= '0;
    end else if (fl_cmd) begin
      gap  <= GAP_W'(1);
      rd_n <= '0;
    end else begin
      if (gap < GAP_W'(INIT_WAIT + 1)) gap <= gap + GAP_W'(1);
      if (fl_rd) rd_n <= rd_n + RD_W'(1);
    end
  end

  AST_CMD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd |-> (!cpu_ready && $past(cpu_ready)));                        // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ready && !fl_cmd) |-> $stable(fl_addr));                       // R10
  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> (gap >= GAP_W'(INIT_WAIT + 1)));                           // R4
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> !cpu_ready);                                               // R5
  AST_DONE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n == RD_W'(TOTAL)));                                    // R8
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cpu_ready && $fell(fl_rd)));                               // R8
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cpu_ready && !done && rd_n == '0));                         // R9
endmodule

bind flash_page_fetch flash_page_fetch_chk #(
  .PAGE_W(PAGE_W), .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
  .INIT_WAIT(INIT_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .fl_cmd(fl_cmd),
  .fl_addr(fl_addr), .fl_rd(fl_rd), .done(done), .err(err)
);

// File: tb/flash_page_fetch_tb.sv
module flash_page_fetch_tb;
  localparam int INIT = 16;
  localparam int BC   = 2;
  localparam int TMO  = 40;
  localparam int NV   = 8;

  // page16, busy8, pri2, pfv1, pf16
  localparam logic [42:0] VEC [NV] = '{
    {16'h0012, 8'd0,  2'b00, 1'b1, 16'h0013},
    {16'h006A, 8'd5,  2'b01, 1'b0, 16'hBEEF},
    {16'h00FF, 8'd16, 2'b10, 1'b1, 16'h1234},
    {16'h00E0, 8'd25, 2'b01, 1'b1, 16'h0000},
    {16'hFFFF, 8'd17, 2'b00, 1'b0, 16'hFFFF},
    {16'h0400, 8'd15, 2'b10, 1'b0, 16'h8001},
    {16'h0061, 8'd1,  2'b00, 1'b1, 16'hA5A5},
    {16'h1000, 8'd30, 2'b01, 1'b1, 16'h7FFE}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_page = '0;
  logic cpu_ready, fl_cmd, fl_rb, fl_rd, lb_we, done, err, pf_valid;
  logic map_we = 1'b0, map_en = 1'b0;
  logic [1:0] map_sel = '0;
  logic [10:0] map_bad = '0, map_good = '0;
  logic [15:0] fl_addr, pf_page;
  logic [7:0] fl_data, lb_data;
  logic [8:0] lb_addr;
  logic [1:0] pri;

  int checks = 0, fails = 0;
  int rb_cnt = 1000, cur_busy = 0, dev_idx = 0;
  logic [15:0] dev_addr = '0, exp_ph = '0;
  logic [1:0] cur_pri = '0;
  logic cur_pfv = 1'b0;
  logic [15:0] cur_pf = '0;
  int wr_n = 0, bad_wr = 0, cmd_n = 0;
  bit t_en [4];
  logic [10:0] t_bad [4], t_good [4];

  always #10 clk = ~clk;

  flash_page_fetch #(.INIT_WAIT(INIT), .BYTE_CYC(BC), .RB_TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
    .cpu_ready(cpu_ready), .map_we(map_we), .map_sel(map_sel), .map_en(map_en),
    .map_bad(map_bad), .map_good(map_good), .fl_cmd(fl_cmd), .fl_addr(fl_addr),
    .fl_rb(fl_rb), .fl_rd(fl_rd), .fl_data(fl_data), .lb_we(lb_we),
    .lb_addr(lb_addr), .lb_data(lb_data), .done(done), .err(err), .pri(pri),
    .pf_valid(pf_valid), .pf_page(pf_page));

  function automatic logic [7:0] dev_byte(logic [15:0] pg, int i);
    if (i < 512) return (pg[7:0] ^ pg[15:8]) + 8'(i) + {7'b0, i[8]};
    if (i == 512) return {cur_pfv, 5'b0, cur_pri};
    if (i == 513) return cur_pf[15:8];
    if (i == 514) return cur_pf[7:0];
    return 8'hC3;
  endfunction

  function automatic logic [15:0] remap(logic [15:0] pg);
    logic [10:0] b = pg[15:5];
    for (int i = 3; i >= 0; i--)
      if (t_en[i] && t_bad[i] == pg[15:5]) b = t_good[i];
    return {b, pg[4:0]};
  endfunction

  // device model
  assign fl_rb   = (rb_cnt >= cur_busy);
  assign fl_data = dev_byte(dev_addr, dev_idx);
  always @(posedge clk) begin
    if (!rst_n) rb_cnt <= 1000;
    else if (fl_cmd) rb_cnt <= 0;
    else if (rb_cnt < 1000) rb_cnt <= rb_cnt + 1;
    if (fl_cmd) begin dev_addr <= fl_addr; dev_idx <= 0; end
    else if (fl_rd) dev_idx <= dev_idx + 1;
  end

  always @(negedge clk) begin
    if (lb_we) begin
      if (lb_addr !== 9'(wr_n) || lb_data !== dev_byte(exp_ph, wr_n)) bad_wr++;
      wr_n++;
    end
    if (fl_cmd) cmd_n++;
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_map(int sel, bit en, logic [10:0] bad, logic [10:0] good);
    @(negedge clk);
    map_we = 1'b1; map_sel = 2'(sel); map_en = en; map_bad = bad; map_good = good;
    t_en[sel] = en; t_bad[sel] = bad; t_good[sel] = good;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic run_fetch(logic [15:0] pg, int busy, logic [1:0] p, logic v,
                           logic [15:0] pf, bit expect_err);
    int cyc, d, exp_cyc;
    @(negedge clk);
    cur_busy = busy; cur_pri = p; cur_pfv = v; cur_pf = pf;
    exp_ph = remap(pg);
    wr_n = 0; bad_wr = 0; cmd_n = 0;
    req_valid = 1'b1; req_page = pg;
    @(negedge clk);
    req_valid = 1'b0;
    check(fl_cmd === 1'b1 && cpu_ready === 1'b0, "R2 command cycle", {fl_cmd, cpu_ready}, 2'b10);
    check(fl_addr === exp_ph, "R3 physical page", fl_addr, exp_ph);
    cyc = 0;
    while (!cpu_ready && cyc < 5000) begin
      cyc++;
      if (cyc == 5) begin req_valid = 1'b1; req_page = pg ^ 16'h0020; end
      else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    d = (busy + 1 > INIT) ? busy + 1 - INIT : 0;
    exp_cyc = expect_err ? INIT + TMO : INIT + 1 + d + 528 * BC;
    check(cyc == exp_cyc, expect_err ? "R9 stall length" : "R8 stall length", cyc, exp_cyc);
    check(cmd_n == 1 && fl_addr === exp_ph, "R10 busy request ignored", cmd_n, 1);
    if (expect_err) begin
      check(err === 1'b1 && done === 1'b0, "R9 timeout pulse", {err, done}, 2'b10);
      check(wr_n == 0, "R9 no line writes", wr_n, 0);
    end else begin
      check(done === 1'b1 && err === 1'b0, "R8 done with ready", {done, err}, 2'b10);
      check(wr_n == 512 && bad_wr == 0, "R6 line buffer contents", bad_wr, 0);
      check(pri === p && pf_valid === v, "R7 priority and hint flag", {pri, pf_valid}, {p, v});
      check(pf_page === pf, "R7 prefetch page", pf_page, pf);
    end
    @(negedge clk);
    check(done === 1'b0 && err === 1'b0, "R8 single cycle pulse", {done, err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin t_en[i] = 0; t_bad[i] = '0; t_good[i] = '0; end
    repeat (3) @(negedge clk);
    check(cpu_ready === 1'b1 && done === 1'b0 && err === 1'b0 && fl_cmd === 1'b0
          && fl_rd === 1'b0 && lb_we === 1'b0, "R1 reset state", cpu_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready === 1'b1, "R1 idle after reset", cpu_ready, 1);
    set_map(1, 1'b1, 11'd3, 11'd40);
    set_map(2, 1'b1, 11'd7, 11'd9);
    set_map(3, 1'b1, 11'd7, 11'd100);   // R3 lower index must win
    for (int i = 0; i < NV; i++)
      run_fetch(VEC[i][42:27], int'(VEC[i][26:19]), VEC[i][18:17], VEC[i][16],
                VEC[i][15:0], 1'b0);    // R4 R5 via busy lengths
    run_fetch(16'h0033, 100000, 2'b00, 1'b0, 16'h0, 1'b1);       // R9
    set_map(1, 1'b0, 11'd3, 11'd40);                              // R11 disable
    run_fetch(16'h006A, 2, 2'b10, 1'b1, 16'h4242, 1'b0);
    check(exp_ph == 16'h006A, "R11 entry removed", exp_ph, 16'h006A);
    set_map(0, 1'b1, 11'd128, 11'd5);                             // R11 new entry
    run_fetch(16'h1003, 0, 2'b01, 1'b0, 16'h0101, 1'b0);
    check(exp_ph == 16'h00A3, "R11 entry applied", exp_ph, 16'h00A3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule